// File: doc/BRIEF.md
# Separator-Tagged Serial Command Decoder

This block sits behind a byte-wide serial receiver and reads the commands that a host sends as a flat stream of bytes. Bytes are paired by position: every odd byte is a tag that names a setting, and the byte after it is the value for that setting. The block keeps the current value of a target device address, a two-byte register address, a two-byte data word, a PWM period and a PWM pulse width. It fires a one-cycle start strobe to an external write sequencer when the host sends the send tag.

The PWM settings also go to a downstream consumer. Each PWM tag byte, and then its value byte, is copied onto a byte output with a valid/ready handshake. A two-entry buffer holds these bytes while the consumer stalls. A bad tag does not break the pairing, because the block treats the byte after it as a tag again. The send tag takes no value byte.

Top module: `sep_cmd_decoder`

## Requirements
- R1: After reset, pwm_period is 0xB4 and pwm_width is 0x14. dev_addr, reg_addr_hi, reg_addr_lo, wr_data_hi and wr_data_lo are 0x00, and send_pulse, busy_err and fwd_valid are 0.
- R2: The first byte after reset is a tag, and the byte after each recognised value tag is its value. The value tags are:
  - 0xAA selects dev_addr
  - 0x4D selects reg_addr_hi
  - 0x4E selects reg_addr_lo
  - 0x4F selects wr_data_hi
  - 0x50 selects wr_data_lo
  - 0x51 selects pwm_period
  - 0x52 selects pwm_width

  The value byte appears on its output in the cycle after its rx_valid strobe.
- R3: A tag byte with any code other than the eight listed changes no output, and the byte after it is again decoded as a tag.
- R4: Tag 0x53 raises send_pulse for exactly one cycle, the cycle after its strobe. It consumes no value byte, so the next byte is decoded as a tag.
- R5: If seq_busy is high when tag 0x53 is strobed, send_pulse stays low and busy_err goes high. busy_err then stays high until reset.
- R6: Tags 0x51 and 0x52 are placed on the forward output as soon as they arrive. Their value byte follows, in arrival order.
- R7: While fwd_ready is low, fwd_valid and fwd_data hold steady. The buffer keeps up to two bytes, and a byte that arrives while both entries are occupied and no byte leaves is dropped.
- R8: Value bytes for tags other than 0x51 and 0x52, and the tags themselves, are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe per received byte |
| rx_byte | input | 8 | Received byte |
| seq_busy | input | 1 | Write sequencer is busy |
| dev_addr | output | 8 | Target device address |
| reg_addr_hi | output | 8 | Register address, upper byte |
| reg_addr_lo | output | 8 | Register address, lower byte |
| wr_data_hi | output | 8 | Write data, upper byte |
| wr_data_lo | output | 8 | Write data, lower byte |
| pwm_period | output | 8 | PWM period setting |
| pwm_width | output | 8 | PWM pulse-width setting |
| send_pulse | output | 1 | One-cycle start strobe to the sequencer |
| busy_err | output | 1 | Sticky flag: a send was refused because the sequencer was busy |
| fwd_valid | output | 1 | Forward byte available |
| fwd_data | output | 8 | Forward byte |
| fwd_ready | input | 1 | Downstream accepts the forward byte |

## Verification
The hardest state to reach is a full forward buffer that then receives another PWM tag and value. Only a consumer held stalled across two complete PWM pairs produces it. The stimulus holds fwd_ready low through two pairs, then lets exactly one byte out per cycle. It checks that the first pair comes out intact and in order, that the dropped pair did not reach the output, and that the register update still took effect. Losing tag parity is shown through the ports alone: a stray tag or a send tag is followed by a tagged value, and the value must land in the right register.

// File: rtl/sepdec_pkg.sv
package sepdec_pkg;

  localparam int BYTE_W = 8;
  localparam int NUM_TGT = 7;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_DEV  = 3'd1,
    TGT_RAH  = 3'd2,
    TGT_RAL  = 3'd3,
    TGT_DH   = 3'd4,
    TGT_DL   = 3'd5,
    TGT_PER  = 3'd6,
    TGT_WID  = 3'd7
  } tgt_e;

  localparam logic [BYTE_W-1:0] CODE_DEV  = 8'hAA;
  localparam logic [BYTE_W-1:0] CODE_RAH  = 8'h4D;
  localparam logic [BYTE_W-1:0] CODE_RAL  = 8'h4E;
  localparam logic [BYTE_W-1:0] CODE_DH   = 8'h4F;
  localparam logic [BYTE_W-1:0] CODE_DL   = 8'h50;
  localparam logic [BYTE_W-1:0] CODE_PER  = 8'h51;
  localparam logic [BYTE_W-1:0] CODE_WID  = 8'h52;
  localparam logic [BYTE_W-1:0] CODE_SEND = 8'h53;

  function automatic tgt_e decode_tag(input logic [BYTE_W-1:0] b);
    case (b)
      CODE_DEV: return TGT_DEV;
      CODE_RAH: return TGT_RAH;
      CODE_RAL: return TGT_RAL;
      CODE_DH:  return TGT_DH;
      CODE_DL:  return TGT_DL;
      CODE_PER: return TGT_PER;
      CODE_WID: return TGT_WID;
      default:  return TGT_NONE;
    endcase
  endfunction

  function automatic logic is_fwd_tgt(input tgt_e t);
    return (t == TGT_PER) || (t == TGT_WID);
  endfunction

endpackage

// File: rtl/sepdec_parser.sv
module sepdec_parser
  import sepdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              seq_busy,
  output logic              wr_en,
  output tgt_e              wr_tgt,
  output logic              push_en,
  output logic [BYTE_W-1:0] push_data,
  output logic              send_pulse,
  output logic              busy_err
);

  logic phase_q, phase_d;
  tgt_e sel_q, sel_d;
  logic send_q, send_d;
  logic err_q, err_d;
  tgt_e tag_t;

  assign tag_t = decode_tag(rx_byte);

  always_comb begin
    phase_d   = phase_q;
    sel_d     = sel_q;
    send_d    = 1'b0;
    err_d     = err_q;
    wr_en     = 1'b0;
    wr_tgt    = sel_q;
    push_en   = 1'b0;
    push_data = rx_byte;
    if (rx_valid) begin
      if (!phase_q) begin
        if (tag_t != TGT_NONE) begin
          sel_d   = tag_t;
          phase_d = 1'b1;
          push_en = is_fwd_tgt(tag_t);
        end else begin
          sel_d = TGT_NONE;
          if (rx_byte == CODE_SEND) begin
            if (seq_busy) err_d  = 1'b1;
            else          send_d = 1'b1;
          end
        end
      end else begin
        phase_d = 1'b0;
        if (sel_q != TGT_NONE) begin
          wr_en   = 1'b1;
          push_en = is_fwd_tgt(sel_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      sel_q   <= TGT_NONE;
      send_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sel_q   <= sel_d;
      send_q  <= send_d;
      err_q   <= err_d;
    end
  end

  assign send_pulse = send_q;
  assign busy_err   = err_q;

endmodule

// File: rtl/sepdec_regs.sv
module sepdec_regs
  import sepdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PER_RST = 8'hB4,
  parameter logic [BYTE_W-1:0] WID_RST = 8'h14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  tgt_e                      wr_tgt,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic [NUM_TGT*BYTE_W-1:0] bank
);

  for (genvar i = 1; i <= NUM_TGT; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] RST_V =
      (i == int'(TGT_PER)) ? PER_RST :
      (i == int'(TGT_WID)) ? WID_RST : '0;
    logic [BYTE_W-1:0] q;
    logic              ce;
    assign ce = wr_en && (int'(wr_tgt) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_V;
      else if (ce) q <= wr_data;
    end
    assign bank[(i-1)*BYTE_W +: BYTE_W] = q;
  end

endmodule

// File: rtl/sepdec_fifo.sv
module sepdec_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop, do_push;

  assign do_pop  = (cnt_q != '0) && out_ready;
  assign do_push = push && ((cnt_q != FULL) || do_pop);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= push_data;
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rp_q];

endmodule

// File: rtl/sep_cmd_decoder.sv
module sep_cmd_decoder
  import sepdec_pkg::*;
#(
  parameter int                FWD_DEPTH = 2,
  parameter logic [BYTE_W-1:0] PER_RST   = 8'hB4,
  parameter logic [BYTE_W-1:0] WID_RST   = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              seq_busy,
  output logic [BYTE_W-1:0] dev_addr,
  output logic [BYTE_W-1:0] reg_addr_hi,
  output logic [BYTE_W-1:0] reg_addr_lo,
  output logic [BYTE_W-1:0] wr_data_hi,
  output logic [BYTE_W-1:0] wr_data_lo,
  output logic [BYTE_W-1:0] pwm_period,
  output logic [BYTE_W-1:0] pwm_width,
  output logic              send_pulse,
  output logic              busy_err,
  output logic              fwd_valid,
  output logic [BYTE_W-1:0] fwd_data,
  input  logic              fwd_ready
);

  logic                      wr_en, push_en;
  tgt_e                      wr_tgt;
  logic [BYTE_W-1:0]         push_data;
  logic [NUM_TGT*BYTE_W-1:0] bank;

  sepdec_parser u_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .seq_busy(seq_busy), .wr_en(wr_en), .wr_tgt(wr_tgt), .push_en(push_en),
    .push_data(push_data), .send_pulse(send_pulse), .busy_err(busy_err)
  );

  sepdec_regs #(.PER_RST(PER_RST), .WID_RST(WID_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
    .wr_data(rx_byte), .bank(bank)
  );

  sepdec_fifo #(.W(BYTE_W), .DEPTH(FWD_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_en), .push_data(push_data),
    .out_valid(fwd_valid), .out_data(fwd_data), .out_ready(fwd_ready)
  );

  assign dev_addr    = bank[0*BYTE_W +: BYTE_W];
  assign reg_addr_hi = bank[1*BYTE_W +: BYTE_W];
  assign reg_addr_lo = bank[2*BYTE_W +: BYTE_W];
  assign wr_data_hi  = bank[3*BYTE_W +: BYTE_W];
  assign wr_data_lo  = bank[4*BYTE_W +: BYTE_W];
  assign pwm_period  = bank[5*BYTE_W +: BYTE_W];
  assign pwm_width   = bank[6*BYTE_W +: BYTE_W];

endmodule

// File: rtl/sepdec_checker.sv
module sepdec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       seq_busy,
  input logic [7:0] pwm_period,
  input logic [7:0] dev_addr,
  input logic       send_pulse,
  input logic       busy_err,
  input logic       fwd_valid,
  input logic [7:0] fwd_data,
  input logic       fwd_ready
);

  assert_send_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    send_pulse |-> $past(rx_valid) && $past(rx_byte) == 8'h53);

  assert_no_send_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    send_pulse |-> !$past(seq_busy));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |=> busy_err);

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_data));

  assert_reg_on_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_period) || !$stable(dev_addr) |-> $past(rx_valid));

endmodule

bind sep_cmd_decoder sepdec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .seq_busy(seq_busy), .pwm_period(pwm_period), .dev_addr(dev_addr),
  .send_pulse(send_pulse), .busy_err(busy_err), .fwd_valid(fwd_valid),
  .fwd_data(fwd_data), .fwd_ready(fwd_ready)
);

// File: tb/sep_cmd_decoder_bench.sv
module sep_cmd_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, seq_busy, fwd_ready;
  logic [7:0] rx_byte;
  logic [7:0] dev_addr, reg_addr_hi, reg_addr_lo, wr_data_hi, wr_data_lo;
  logic [7:0] pwm_period, pwm_width, fwd_data;
  logic       send_pulse, busy_err, fwd_valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic pulse_seen;

  always #5 clk = ~clk;

  sep_cmd_decoder u_sep_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .seq_busy(seq_busy), .dev_addr(dev_addr), .reg_addr_hi(reg_addr_hi),
    .reg_addr_lo(reg_addr_lo), .wr_data_hi(wr_data_hi), .wr_data_lo(wr_data_lo),
    .pwm_period(pwm_period), .pwm_width(pwm_width), .send_pulse(send_pulse),
    .busy_err(busy_err), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .fwd_ready(fwd_ready)
  );

  // {tag, value, expected forward flag}
  localparam logic [16:0] VEC [7] = '{
    {8'hAA, 8'h5A, 1'b0}, {8'h4D, 8'h12, 1'b0}, {8'h4E, 8'h34, 1'b0},
    {8'h4F, 8'h56, 1'b0}, {8'h50, 8'h78, 1'b0}, {8'h51, 8'hC8, 1'b1},
    {8'h52, 8'h3C, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid   = 1'b0;
    pulse_seen = send_pulse;
  endtask

  function automatic logic [7:0] sel_out(input logic [7:0] tag);
    case (tag)
      8'hAA:   return dev_addr;
      8'h4D:   return reg_addr_hi;
      8'h4E:   return reg_addr_lo;
      8'h4F:   return wr_data_hi;
      8'h50:   return wr_data_lo;
      8'h51:   return pwm_period;
      default: return pwm_width;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = '0; seq_busy = 1'b0; fwd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 period", pwm_period, 8'hB4);
    chk("R1 width", pwm_width, 8'h14);
    chk("R1 dev", dev_addr, 8'h00);
    chk("R1 rah", reg_addr_hi, 8'h00);
    chk("R1 ral", reg_addr_lo, 8'h00);
    chk("R1 dh", wr_data_hi, 8'h00);
    chk("R1 dl", wr_data_lo, 8'h00);
    chk("R1 flags", {5'd0, send_pulse, busy_err, fwd_valid}, 8'h00);

    // R2 table walk, R6 forwarding, R8 no forwarding of other values
    for (int i = 0; i < 7; i++) begin
      logic [7:0] tg, vl;
      logic fw, saw_tag, saw_val;
      tg = VEC[i][16:9];
      vl = VEC[i][8:1];
      fw = VEC[i][0];
      saw_tag = 1'b0;
      saw_val = 1'b0;
      send_byte(tg);
      if (fwd_valid && fwd_data == tg) saw_tag = 1'b1;
      send_byte(vl);
      if (fwd_valid && fwd_data == vl) saw_val = 1'b1;
      chk("R2 value write", sel_out(tg), vl);
      chk("R6/R8 forward", {6'd0, saw_tag, saw_val}, {6'd0, fw, fw});
    end

    // R3 unknown tag then a valid pair
    send_byte(8'h77);
    chk("R3 no change", dev_addr, 8'h5A);
    send_byte(8'hAA);
    send_byte(8'h3E);
    chk("R3 resync", dev_addr, 8'h3E);

    // R4 send tag
    send_byte(8'h53);
    chk("R4 pulse", {7'd0, pulse_seen}, 8'h01);
    @(negedge clk);
    chk("R4 one cycle", {7'd0, send_pulse}, 8'h00);
    send_byte(8'h4D);
    send_byte(8'h9E);
    chk("R4 no value", reg_addr_hi, 8'h9E);

    // R5 send while busy
    seq_busy = 1'b1;
    send_byte(8'h53);
    chk("R5 suppressed", {7'd0, pulse_seen}, 8'h00);
    chk("R5 err set", {7'd0, busy_err}, 8'h01);
    seq_busy = 1'b0;
    send_byte(8'h53);
    chk("R5 pulse after", {7'd0, pulse_seen}, 8'h01);
    chk("R5 sticky", {7'd0, busy_err}, 8'h01);

    // R7 stall, fill, overflow drop
    fwd_ready = 1'b0;
    send_byte(8'h51);
    send_byte(8'h33);
    send_byte(8'h52);
    send_byte(8'h44);
    repeat (3) @(negedge clk);
    chk("R7 held valid", {7'd0, fwd_valid}, 8'h01);
    chk("R7 head", fwd_data, 8'h51);
    chk("R7 reg still written", pwm_width, 8'h44);
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    chk("R7 second", fwd_data, 8'h33);
    chk("R6 period", pwm_period, 8'h33);
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    chk("R7 dropped pair", {7'd0, fwd_valid}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule